// File: doc/BRIEF.md
# UART Receive Character Queue with Level Interrupt

This block holds the characters a UART-style serial port has received until software fetches them through its data register. Characters arrive from three places: the deserializer (a valid/ready stream), the transmit loopback path (used only while loopback is on), and a line-break event that stores a marker character. Each stored entry is 12 bits wide. Bits [7:0] carry the data byte. Bits [8], [9] and [10] flag framing, parity and break errors, and bit [11] flags an overrun.

The queue has two depths, chosen at run time. It is a 16-entry circular buffer while the queue-enable control bit is high, and a single holding register while that bit is low. Toggling the bit empties the queue and also sends a one-cycle pulse that the transmit side uses to empty its own queue.

A receive interrupt status bit is set by the push that brings the count to the trigger level. It is cleared by the read that leaves the count one below that level. The trigger level sits at 1 and returns to 1 on every configuration write. Each data-register read copies the error bits of the entry just read into a separate status output. Software clears that status output with a write.

Stream rules on the deserializer side are as follows. A beat transfers in any cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only when the queue is below its current depth, no break event is present and no flush is in progress. A transferred beat is discarded without being stored while loopback is on. Within a cycle, a data-register read is applied before the push.

Top module: `uart_rx_queue`

## Requirements
- R1: The effective depth is 16 while `fifo_en` is high and 1 while it is low. `rx_ready` is high only when the stored count is below that depth, `brk_evt` is low and no flush is taking place.
- R2: Reads return entries oldest first. `rd_data` always shows the entry at the head. The entry layout is data [7:0], framing [8], parity [9], break [10], overrun [11]. A deserializer beat stores `{1'b0, rx_err, rx_data}` with `rx_err` = {break, parity, framing}.
- R3: `empty` is high exactly when the count is zero. `full` is high exactly when the count equals the effective depth.
- R4: `rx_irq` rises on the push that brings the count to the trigger level of 1. It falls on the read that leaves the count at 0, and it falls on `irq_clr`. In the same cycle, a push that sets the bit wins over a clear. `cfg_wr` forces the trigger level back to 1.
- R5: A read while empty changes neither the count nor the flags.
- R6: A read loads `rsr` with bits [11:8] of the entry it returns. `rsr_clr` sets `rsr` to zero.
- R7: Any change of `fifo_en` pulses `tx_flush` for one cycle and empties the queue. Reads and pushes in that cycle are dropped, and `rx_irq` keeps its value.
- R8: While `loopback` is high, deserializer beats and break events are dropped and `lb_valid` pushes `{1'b0, lb_brk, 2'b00, lb_data}`. While `loopback` is low, `lb_valid` is ignored.
- R9: With loopback low, `brk_evt` pushes the entry 0x400 (data zero, break bit set).
- R10: A push while full is not stored and leaves the count at the depth. It sets bit [11] of the newest stored entry.
- R11: Synchronous active-high `rst` leaves the queue empty, `rx_irq` low, `rsr` zero and the trigger level at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue-enable control bit (16 deep when high, 1 deep when low) |
| loopback | input | 1 | Loopback mode enable |
| cfg_wr | input | 1 | Pulse: line-control or level register written |
| rx_valid | input | 1 | Deserializer character valid |
| rx_ready | output | 1 | Queue can accept a deserializer character |
| rx_data | input | 8 | Deserializer data byte |
| rx_err | input | 3 | Deserializer error flags {break, parity, framing} |
| lb_valid | input | 1 | Loopback character pulse |
| lb_data | input | 8 | Loopback data byte |
| lb_brk | input | 1 | Loopback character is a break marker |
| brk_evt | input | 1 | Pulse: line break detected |
| rd | input | 1 | Pulse: data-register read |
| rd_data | output | 12 | Entry at the head of the queue |
| rsr | output | 4 | Error status of the last entry read |
| rsr_clr | input | 1 | Pulse: clear the error status |
| irq_clr | input | 1 | Pulse: clear the receive interrupt status |
| rx_irq | output | 1 | Receive interrupt status bit |
| empty | output | 1 | Queue empty flag |
| full | output | 1 | Queue full flag |
| tx_flush | output | 1 | One-cycle pulse telling the transmit queue to empty |

## Verification
The assertions assume that `rd`, `cfg_wr`, `rsr_clr`, `irq_clr`, `brk_evt` and `lb_valid` are single-cycle pulses. They also assume that `fifo_en` changes only between accesses and is never toggled back within one cycle. The rest of the logic is in reset whenever `rst` is high. The stimulus drives each pulse for exactly one clock and changes the mode bit only while every pulse is low. It also reads only a non-empty queue, except in the one step that checks the empty-read case. That way the error status never depends on an entry that was never written.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int ENTRY_W = 12;
  localparam int BIT_FE  = 8;
  localparam int BIT_PE  = 9;
  localparam int BIT_BE  = 10;
  localparam int BIT_OE  = 11;
  localparam int STAT_W  = ENTRY_W - DATA_W;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RX   = 2'd1,
    SRC_BRK  = 2'd2,
    SRC_LB   = 2'd3
  } push_src_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [PTR_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic               mark_ovr,
  input  logic [PTR_W-1:0]   ovr_idx,
  input  logic [PTR_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  logic [ENTRY_W-1:0] mem [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[s] <= '0;
      end else if (wr_en && wr_idx == PTR_W'(s)) begin
        mem[s] <= wr_data;
      end else if (mark_ovr && ovr_idx == PTR_W'(s)) begin
        mem[s][BIT_OE] <= 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             loopback,
  input  logic             cfg_wr,
  input  logic             rx_valid,
  input  logic             brk_evt,
  input  logic             lb_valid,
  input  logic             rd,
  input  logic             irq_clr,
  output logic             rx_ready,
  output push_src_e        push_src,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic             mark_ovr,
  output logic [PTR_W-1:0] ovr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             rd_do,
  output logic             empty,
  output logic             full,
  output logic             irq,
  output logic             flush
);
  logic             en_q;
  logic [CNT_W-1:0] cnt, cnt_a, cnt_n, trig, depth_eff;
  logic [PTR_W-1:0] ptr, ptr_a, mask;
  logic             irq_n, room, pop;

  assign flush     = (fifo_en != en_q);
  assign depth_eff = en_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign mask      = PTR_W'(depth_eff - CNT_W'(1));
  assign empty     = (cnt == '0);
  assign full      = (cnt == depth_eff);
  assign rd_idx    = ptr;
  assign rx_ready  = !flush && !brk_evt && (cnt < depth_eff);

  always_comb begin
    push_src = SRC_NONE;
    if (!flush) begin
      if (loopback) begin
        if (lb_valid) push_src = SRC_LB;
      end else if (brk_evt) begin
        push_src = SRC_BRK;
      end else if (rx_valid && rx_ready) begin
        push_src = SRC_RX;
      end
    end
  end

  assign rd_do    = rd && !flush;
  assign pop      = rd_do && (cnt != '0);
  assign cnt_a    = pop ? cnt - CNT_W'(1) : cnt;
  assign ptr_a    = pop ? ((ptr + PTR_W'(1)) & mask) : ptr;
  assign room     = (cnt_a < depth_eff);
  assign wr_en    = (push_src != SRC_NONE) && room;
  assign mark_ovr = (push_src != SRC_NONE) && !room;
  assign wr_idx   = (ptr_a + PTR_W'(cnt_a)) & mask;
  assign ovr_idx  = (ptr_a + PTR_W'(cnt_a) - PTR_W'(1)) & mask;
  assign cnt_n    = wr_en ? cnt_a + CNT_W'(1) : cnt_a;

  always_comb begin
    irq_n = irq;
    if (irq_clr) irq_n = 1'b0;
    if (rd_do && (cnt_a + CNT_W'(1) == trig)) irq_n = 1'b0;
    if (wr_en && (cnt_a + CNT_W'(1) == trig)) irq_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= fifo_en;
      cnt  <= '0;
      ptr  <= '0;
      irq  <= 1'b0;
      trig <= CNT_W'(1);
    end else begin
      en_q <= fifo_en;
      irq  <= irq_n;
      if (cfg_wr) trig <= CNT_W'(1);
      if (flush) begin
        cnt <= '0;
        ptr <= '0;
      end else begin
        cnt <= cnt_n;
        ptr <= ptr_a;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= depth_eff); // R1
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (rst)
    (rd && empty && !flush && push_src == SRC_NONE) |=> empty); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty); // R7
  AST_FIRST_PUSH_IRQ: assert property (@(posedge clk) disable iff (rst)
    (empty && wr_en) |=> irq); // R4
  AST_OVERRUN_STAYS_FULL: assert property (@(posedge clk) disable iff (rst)
    (mark_ovr && !fifo_en == !en_q) |=> full); // R10
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [STAT_W-1:0] err_in,
  input  logic              clr,
  output logic [STAT_W-1:0] rsr
);
  always_ff @(posedge clk) begin
    if (rst || clr) rsr <= '0;
    else if (cap)   rsr <= err_in;
  end

  AST_RSR_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rsr == '0)); // R6
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_en,
  input  logic               loopback,
  input  logic               cfg_wr,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic [2:0]         rx_err,
  input  logic               lb_valid,
  input  logic [DATA_W-1:0]  lb_data,
  input  logic               lb_brk,
  input  logic               brk_evt,
  input  logic               rd,
  output logic [ENTRY_W-1:0] rd_data,
  output logic [STAT_W-1:0]  rsr,
  input  logic               rsr_clr,
  input  logic               irq_clr,
  output logic               rx_irq,
  output logic               empty,
  output logic               full,
  output logic               tx_flush
);
  localparam int PTR_W = $clog2(DEPTH);

  push_src_e          push_src;
  logic               wr_en, mark_ovr, rd_do;
  logic [PTR_W-1:0]   wr_idx, ovr_idx, rd_idx;
  logic [ENTRY_W-1:0] wr_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .loopback (loopback),
    .cfg_wr   (cfg_wr),
    .rx_valid (rx_valid),
    .brk_evt  (brk_evt),
    .lb_valid (lb_valid),
    .rd       (rd),
    .irq_clr  (irq_clr),
    .rx_ready (rx_ready),
    .push_src (push_src),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .mark_ovr (mark_ovr),
    .ovr_idx  (ovr_idx),
    .rd_idx   (rd_idx),
    .rd_do    (rd_do),
    .empty    (empty),
    .full     (full),
    .irq      (rx_irq),
    .flush    (tx_flush)
  );

  always_comb begin
    unique case (push_src)
      SRC_RX:  wr_data = {1'b0, rx_err, rx_data};
      SRC_BRK: wr_data = ENTRY_W'(1) << BIT_BE;
      SRC_LB:  wr_data = {1'b0, lb_brk, 2'b00, lb_data};
      default: wr_data = '0;
    endcase
  end

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .mark_ovr (mark_ovr),
    .ovr_idx  (ovr_idx),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  rxq_status u_status (
    .clk    (clk),
    .rst    (rst),
    .cap    (rd_do),
    .err_in (rd_data[ENTRY_W-1:DATA_W]),
    .clr    (rsr_clr),
    .rsr    (rsr)
  );

  AST_NO_READY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !rx_ready); // R1
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R3
endmodule

// File: tb/tb_uart_rx_queue.sv
module tb_uart_rx_queue;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fifo_en = 1'b1, loopback = 1'b0, cfg_wr = 1'b0;
  logic        rx_valid = 1'b0, lb_valid = 1'b0, lb_brk = 1'b0, brk_evt = 1'b0;
  logic        rd = 1'b0, rsr_clr = 1'b0, irq_clr = 1'b0;
  logic [7:0]  rx_data = '0, lb_data = '0;
  logic [2:0]  rx_err = '0;
  logic        rx_ready, rx_irq, empty, full, tx_flush;
  logic [11:0] rd_data;
  logic [3:0]  rsr;

  int checks = 0, errors = 0;
  logic [11:0] mq[$];
  logic        m_irq = 1'b0;
  logic [3:0]  m_rsr = '0;
  int          dep = 16;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_queue dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .loopback(loopback), .cfg_wr(cfg_wr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_err(rx_err),
    .lb_valid(lb_valid), .lb_data(lb_data), .lb_brk(lb_brk), .brk_evt(brk_evt),
    .rd(rd), .rd_data(rd_data), .rsr(rsr), .rsr_clr(rsr_clr), .irq_clr(irq_clr),
    .rx_irq(rx_irq), .empty(empty), .full(full), .tx_flush(tx_flush)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    rx_valid = 0; lb_valid = 0; brk_evt = 0; rd = 0;
    cfg_wr = 0; rsr_clr = 0; irq_clr = 0; lb_brk = 0;
  endtask

  function automatic void m_push(logic [11:0] v);
    if (mq.size() < dep) begin
      mq.push_back(v);
      if (mq.size() == 1) m_irq = 1'b1;
    end else begin
      mq[mq.size()-1] = mq[mq.size()-1] | 12'h800;
    end
  endfunction

  task automatic state(string tag);
    chk({tag, " R3 empty"}, empty, mq.size() == 0);
    chk({tag, " R3 full"}, full, mq.size() == dep);
    chk({tag, " R4 irq"}, rx_irq, m_irq);
    chk({tag, " R6 rsr"}, rsr, m_rsr);
  endtask

  task automatic push_rx(logic [7:0] d, logic [2:0] e);
    logic exp_rdy;
    rx_valid = 1; rx_data = d; rx_err = e;
    exp_rdy = (mq.size() < dep);
    #0 chk("R1 rx_ready", rx_ready, exp_rdy);
    tick();
    if (exp_rdy && !loopback) m_push({1'b0, e, d});
  endtask

  task automatic push_lb(logic [7:0] d, logic b);
    lb_valid = 1; lb_data = d; lb_brk = b;
    tick();
    if (loopback) m_push({1'b0, b, 2'b00, d});
  endtask

  task automatic do_read(string tag);
    logic [11:0] seen;
    seen = rd_data;
    if (mq.size() > 0) chk({tag, " R2 rd_data"}, rd_data, mq[0]);
    rd = 1;
    tick();
    m_rsr = seen[11:8];
    if (mq.size() > 0) void'(mq.pop_front());
    if (mq.size() == 0) m_irq = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    rst = 0;
    tick();
    // R11: reset state
    chk("R11 empty", empty, 1);
    chk("R11 full", full, 0);
    chk("R11 irq", rx_irq, 0);
    chk("R11 rsr", rsr, 0);
    chk("R11 ready", rx_ready, 1);

    for (int mode = 1; mode >= 0; mode--) begin
      if (fifo_en != mode[0]) begin
        fifo_en = mode[0];
        tick();
        mq.delete();
      end
      dep = mode ? 16 : 1;
      // R1/R3/R4: fill to depth under a byte pattern
      for (int i = 0; i < dep; i++) begin
        push_rx(8'(i * 37 + mode * 5 + 1), 3'(i % 8));
        state("fill");
      end
      chk("R1 full blocks ready", rx_ready, 0);
      // R10: overrun through loopback marks newest entry
      loopback = 1;
      push_lb(8'h5A, 1'b0);
      state("R10 overrun");
      loopback = 0;
      // R2/R6: drain oldest first
      for (int i = 0; i < dep; i++) begin
        do_read("drain");
        state("drain");
      end
      // R5: read while empty
      do_read("R5 empty read");
      chk("R5 empty stays", empty, 1);
      chk("R5 full stays", full, 0);
      // R8: loopback drops external and break, accepts loopback
      loopback = 1;
      push_rx(8'hAA, 3'b000);
      brk_evt = 1; tick();
      chk("R8 rx/brk dropped", empty, 1);
      push_lb(8'hC3, 1'b1);
      do_read("R8 lb entry");
      state("R8");
      loopback = 0;
      push_lb(8'h11, 1'b0);
      chk("R8 lb ignored", empty, 1);
      // R9: break marker
      brk_evt = 1; rx_valid = 1;
      #0 chk("R9 ready low on break", rx_ready, 0);
      tick();
      m_push(12'h400);
      chk("R9 break entry", rd_data, 12'h400);
      do_read("R9 read");
      state("R9");
    end

    // R7: flush on mode change keeps irq
    fifo_en = 1; tick(); mq.delete(); dep = 16;
    for (int i = 0; i < 3; i++) push_rx(8'(i + 8'h40), 3'b001);
    state("pre-flush");
    fifo_en = 0;
    #0 chk("R7 tx_flush pulse", tx_flush, 1);
    tick(); mq.delete(); dep = 1;
    chk("R7 tx_flush ends", tx_flush, 0);
    state("R7 flushed");
    // R4: interrupt clear and trigger rewrite
    irq_clr = 1; tick(); m_irq = 0;
    state("R4 irq_clr");
    cfg_wr = 1; tick();
    push_rx(8'h77, 3'b000);
    state("R4 after cfg_wr");
    do_read("R4 read");
    state("R4 cleared by read");
    // R6: error status clear
    push_rx(8'h12, 3'b111);
    do_read("R6 read");
    chk("R6 rsr captured", rsr, 4'h7);
    rsr_clr = 1; tick(); m_rsr = 0;
    state("R6 clear");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule